// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers hardware event signals from the surrounding gate array and turns them into the two interrupt lines of an 8-bit CPU. The maskable line is active low. It is a held level: once driven low it stays low until software writes the acknowledge register. The non-maskable line gives a one-cycle pulse for each critical hardware event, such as a power failure or a memory card being inserted or removed. Software never acknowledges it.

Software reads a status byte that combines three kinds of bit. Two bits are group summaries: the four serial-port flags are ANDed with a serial mask register and ORed to one bit, and the three timer flags are ANDed with a timer mask register and ORed to one bit. Some bits are live levels: the lid-open input and the battery-low input. The rest are sticky event flags: a lid-open rising edge, a high top address bit seen during sleep, and a keyboard column falling during sleep. A global enable register picks which status bits may pull the maskable line low. A write-one-to-clear acknowledge register clears the sticky flags and releases the held line.

Registers are written through a simple port. `wr_sel` chooses the target: 0 is the serial mask, 1 is the timer mask, 2 is the interrupt enable, and 3 is the acknowledge register.

Top module: `irq_status_hub`

## Requirements
- R1: The status byte layout is: bit 7 lid-open level, bit 6 address-high-in-sleep flag, bit 5 lid rising-edge flag, bit 4 serial summary, bit 3 battery-low level, bit 2 keyboard-in-sleep flag, bit 0 timer summary. Bit 1 always reads 0.
- R2: Status bit 4 is the OR of `uart_flags[i] & serial_mask[i]`. The flag bits are 0 transmit empty, 1 receive full, 2 carrier change and 3 clear-to-send change. The serial mask is written through `wr_sel`=0 from `wr_data[3:0]`.
- R3: Status bit 0 is the OR of `timer_flags[i] & timer_mask[i]`. The flag bits are 0 tick, 1 second and 2 minute. The timer mask is written through `wr_sel`=1 from `wr_data[2:0]`.
- R4: Bit 7 follows `flap_open`. Bit 5 is set only by a low-to-high change of `flap_open`, never by a steady high level. Bit 3 follows `batt_low`.
- R5: `int_n` is high when nothing enabled is pending. Once `int_n` goes low it stays low until a write with `wr_sel`=3. After that write it is high, unless an enabled bit is still pending, in which case it stays low.
- R6: `nmi` is high for exactly one cycle after each rising edge of `pwr_fail` or `card_change`. Edges on consecutive cycles give consecutive pulses.
- R7: Bit 2 is set when any `kbd_cols` bit falls from 1 to 0 while `sleeping` is high. A column falling while `sleeping` is low has no effect.
- R8: Bit 6 is set when `addr_hi` is high while `sleeping` is high. It stays set after `addr_hi` falls.
- R9: A write with `wr_sel`=3 clears each of status bits 6, 5 and 2 whose `wr_data` bit is 1. Level and summary bits are unaffected. A set condition in the same cycle wins over the clear.
- R10: Only status bits whose bit is 1 in the enable register (`wr_sel`=2) can drive `int_n` low.
- R11: After reset the status byte is 0, all masks are 0, `int_n` is 1 and `nmi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 serial mask, 1 timer mask, 2 enable, 3 acknowledge |
| wr_data | input | 8 | Write data |
| uart_flags | input | 4 | Serial-port interrupt flags |
| timer_flags | input | 3 | Timer interrupt flags |
| flap_open | input | 1 | Lid-open level |
| batt_low | input | 1 | Battery-low level |
| kbd_cols | input | 8 | Keyboard column inputs, idle high |
| addr_hi | input | 1 | Top address bit |
| sleeping | input | 1 | System is in a sleep state |
| pwr_fail | input | 1 | Power-fail event input |
| card_change | input | 1 | Card insertion/removal event input |
| status | output | 8 | Registered status byte |
| int_n | output | 1 | Maskable interrupt, active low, held |
| nmi | output | 1 | Non-maskable interrupt pulse |

## Verification
Every status bit, `int_n` and `nmi` are registered once from inputs sampled at the same rising edge. So a flag, level or event driven before an edge shows at the outputs right after that edge. A mask or enable write is stored at one edge and only takes part in the result at the following edge, so the bench waits one extra edge after each such write before it checks. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which is half a period after the edge that updates them.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int STAT_W = 8;

  localparam int BIT_TIMER = 0;
  localparam int BIT_SPARE = 1;
  localparam int BIT_KBD   = 2;
  localparam int BIT_BATT  = 3;
  localparam int BIT_UART  = 4;
  localparam int BIT_LIDUP = 5;
  localparam int BIT_ADDR  = 6;
  localparam int BIT_LID   = 7;

  localparam logic [1:0] SEL_UMASK = 2'd0;
  localparam logic [1:0] SEL_TMASK = 2'd1;
  localparam logic [1:0] SEL_IEN   = 2'd2;
  localparam logic [1:0] SEL_ACK   = 2'd3;

  localparam logic [STAT_W-1:0] STICKY_BITS =
    STAT_W'((1 << BIT_ADDR) | (1 << BIT_LIDUP) | (1 << BIT_KBD));
endpackage

// File: rtl/irq_mask_reduce.sv
module irq_mask_reduce #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] flags_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             any_o
);
  logic [WIDTH-1:0] hit;
  for (genvar i = 0; i < WIDTH; i++) begin : g_hit
    assign hit[i] = flags_i[i] & mask_i[i];
  end
  assign any_o = |hit;
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise_o[i] |=> !rise_o[i]); // R6
  end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter int UART_SRCS  = 4,
  parameter int TIMER_SRCS = 3,
  parameter int KBD_COLS   = 8,
  parameter int NMI_SRCS   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [STAT_W-1:0]     wr_data,
  input  logic [UART_SRCS-1:0]  uart_flags,
  input  logic [TIMER_SRCS-1:0] timer_flags,
  input  logic                  flap_open,
  input  logic                  batt_low,
  input  logic [KBD_COLS-1:0]   kbd_cols,
  input  logic                  addr_hi,
  input  logic                  sleeping,
  input  logic                  pwr_fail,
  input  logic                  card_change,
  output logic [STAT_W-1:0]     status,
  output logic                  int_n,
  output logic                  nmi
);
  logic [UART_SRCS-1:0]  umask_q;
  logic [TIMER_SRCS-1:0] tmask_q;
  logic [STAT_W-1:0]     ien_q;
  logic [STAT_W-1:0]     stat_q, stat_d, clr_bits;
  logic                  irq_q, nmi_q;
  logic                  ack_wr;
  logic                  uart_any, timer_any;
  logic                  lid_rise, lid_fall_unused;
  logic [KBD_COLS-1:0]   kbd_rise_unused, kbd_fall;
  logic [NMI_SRCS-1:0]   nmi_rise, nmi_fall_unused;
  logic [NMI_SRCS-1:0]   nmi_src;

  assign ack_wr   = wr_en && (wr_sel == SEL_ACK);
  assign clr_bits = ack_wr ? (wr_data & STICKY_BITS) : '0;
  assign nmi_src  = NMI_SRCS'({card_change, pwr_fail});

  always_ff @(posedge clk) begin
    if (rst) begin
      umask_q <= '0;
      tmask_q <= '0;
      ien_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_UMASK: umask_q <= wr_data[UART_SRCS-1:0];
        SEL_TMASK: tmask_q <= wr_data[TIMER_SRCS-1:0];
        SEL_IEN:   ien_q   <= wr_data;
        default:   ;
      endcase
    end
  end

  irq_mask_reduce #(.WIDTH(UART_SRCS)) u_uart_sum (
    .flags_i(uart_flags), .mask_i(umask_q), .any_o(uart_any));

  irq_mask_reduce #(.WIDTH(TIMER_SRCS)) u_timer_sum (
    .flags_i(timer_flags), .mask_i(tmask_q), .any_o(timer_any));

  irq_edge_detect #(.WIDTH(1)) u_lid_edge (
    .clk(clk), .rst(rst), .lvl_i(flap_open),
    .rise_o(lid_rise), .fall_o(lid_fall_unused));

  irq_edge_detect #(.WIDTH(KBD_COLS)) u_kbd_edge (
    .clk(clk), .rst(rst), .lvl_i(kbd_cols),
    .rise_o(kbd_rise_unused), .fall_o(kbd_fall));

  irq_edge_detect #(.WIDTH(NMI_SRCS)) u_nmi_edge (
    .clk(clk), .rst(rst), .lvl_i(nmi_src),
    .rise_o(nmi_rise), .fall_o(nmi_fall_unused));

  always_comb begin
    stat_d            = '0;
    stat_d[BIT_LID]   = flap_open;
    stat_d[BIT_ADDR]  = (stat_q[BIT_ADDR] & ~clr_bits[BIT_ADDR]) | (sleeping & addr_hi);
    stat_d[BIT_LIDUP] = (stat_q[BIT_LIDUP] & ~clr_bits[BIT_LIDUP]) | lid_rise;
    stat_d[BIT_UART]  = uart_any;
    stat_d[BIT_BATT]  = batt_low;
    stat_d[BIT_KBD]   = (stat_q[BIT_KBD] & ~clr_bits[BIT_KBD]) | (sleeping & (|kbd_fall));
    stat_d[BIT_SPARE] = 1'b0;
    stat_d[BIT_TIMER] = timer_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= (irq_q & ~ack_wr) | (|(stat_d & ien_q));
      nmi_q  <= |nmi_rise;
    end
  end

  assign status = stat_q;
  assign int_n  = ~irq_q;
  assign nmi    = nmi_q;

  AST_INT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!int_n && !ack_wr) |=> !int_n); // R5
  AST_INT_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(int_n) |-> $past(ack_wr)); // R5
  AST_LIDUP_WITH_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(status[BIT_LIDUP]) |-> status[BIT_LID]); // R4
  AST_KBD_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    $rose(status[BIT_KBD]) |-> $past(sleeping)); // R7
  AST_ADDR_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    $rose(status[BIT_ADDR]) |-> $past(sleeping && addr_hi)); // R8
  AST_UART_MASKED_OFF: assert property (@(posedge clk) disable iff (rst)
    (umask_q == '0) |=> !status[BIT_UART]); // R2
  AST_TIMER_MASKED_OFF: assert property (@(posedge clk) disable iff (rst)
    (tmask_q == '0) |=> !status[BIT_TIMER]); // R3
  AST_NO_ENABLE_NO_INT: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0 && int_n) |=> int_n); // R10
endmodule

// File: tb/tb_irq_status_hub.sv
module tb_irq_status_hub;
  localparam real CLK_NS = 8.0;

  logic       clk = 0, rst = 1;
  logic       wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] uart_flags = 0;
  logic [2:0] timer_flags = 0;
  logic       flap_open = 0, batt_low = 0, addr_hi = 0, sleeping = 0;
  logic [7:0] kbd_cols = 8'hFF;
  logic       pwr_fail = 0, card_change = 0;
  logic [7:0] status;
  logic       int_n, nmi;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_status_hub dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .uart_flags(uart_flags), .timer_flags(timer_flags), .flap_open(flap_open),
    .batt_low(batt_low), .kbd_cols(kbd_cols), .addr_hi(addr_hi),
    .sleeping(sleeping), .pwr_fail(pwr_fail), .card_change(card_change),
    .status(status), .int_n(int_n), .nmi(nmi));

  // {umask, uflags, tmask, tflags, expected serial bit, expected timer bit}
  localparam logic [15:0] VEC [8] = '{
    {4'b0001, 4'b0001, 3'b000, 3'b111, 1'b1, 1'b0},
    {4'b1110, 4'b0001, 3'b001, 3'b001, 1'b0, 1'b1},
    {4'b0100, 4'b0100, 3'b010, 3'b100, 1'b1, 1'b0},
    {4'b1000, 4'b1000, 3'b100, 3'b100, 1'b1, 1'b1},
    {4'b1111, 4'b0000, 3'b111, 3'b000, 1'b0, 1'b0},
    {4'b0000, 4'b1111, 3'b000, 3'b111, 1'b0, 1'b0},
    {4'b0010, 4'b0011, 3'b110, 3'b010, 1'b1, 1'b1},
    {4'b0101, 4'b1010, 3'b101, 3'b010, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    wr_en = 1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R11 status", status, 8'h00);
    check("R11 int_n", {7'b0, int_n}, 8'h01);
    check("R11 nmi", {7'b0, nmi}, 8'h00);

    // group summaries via vector table
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {4'b0, VEC[i][15:12]});
      wr(2'd1, {5'b0, VEC[i][7:5]});
      uart_flags  = VEC[i][11:8];
      timer_flags = VEC[i][4:2];
      tick();
      check("R2 serial summary", {7'b0, status[4]}, {7'b0, VEC[i][1]});
      check("R3 timer summary", {7'b0, status[0]}, {7'b0, VEC[i][0]});
    end
    uart_flags = 0; timer_flags = 0;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    tick();

    // lid level and edge
    flap_open = 1;
    tick();
    check("R4 lid level", {7'b0, status[7]}, 8'h01);
    check("R4 lid edge", {7'b0, status[5]}, 8'h01);
    wr(2'd3, 8'h20);
    check("R9 clear lid edge", {7'b0, status[5]}, 8'h00);
    check("R9 level kept", {7'b0, status[7]}, 8'h01);
    repeat (3) tick();
    check("R4 steady high no edge", {7'b0, status[5]}, 8'h00);
    batt_low = 1;
    tick();
    check("R4 battery level", {7'b0, status[3]}, 8'h01);
    check("R1 spare bit", {7'b0, status[1]}, 8'h00);
    check("R1 layout", status, 8'h88);
    wr(2'd3, 8'hFF);
    check("R9 levels unaffected", status, 8'h88);

    // keyboard
    kbd_cols = 8'hF7;
    tick();
    check("R7 awake fall ignored", {7'b0, status[2]}, 8'h00);
    kbd_cols = 8'hFF; sleeping = 1;
    tick();
    kbd_cols = 8'hDF;
    tick();
    check("R7 asleep fall", {7'b0, status[2]}, 8'h01);
    kbd_cols = 8'hFF;

    // address line in sleep
    addr_hi = 1;
    tick();
    check("R8 addr in sleep", {7'b0, status[6]}, 8'h01);
    addr_hi = 0;
    tick();
    check("R8 addr sticky", {7'b0, status[6]}, 8'h01);

    // set beats clear
    addr_hi = 1;
    wr(2'd3, 8'h40);
    check("R9 set wins", {7'b0, status[6]}, 8'h01);
    addr_hi = 0;
    wr(2'd3, 8'h44);
    check("R9 clear sticky", status & 8'h44, 8'h00);
    sleeping = 0;

    flap_open = 0; batt_low = 0;
    wr(2'd3, 8'hFF);
    tick();
    check("R11 idle status", status, 8'h00);

    // interrupt line
    batt_low = 1;
    tick();
    check("R10 not enabled", {7'b0, int_n}, 8'h01);
    wr(2'd2, 8'h08);
    tick();
    check("R10 enabled low", {7'b0, int_n}, 8'h00);
    batt_low = 0;
    repeat (2) tick();
    check("R5 held low", {7'b0, int_n}, 8'h00);
    check("R4 battery gone", {7'b0, status[3]}, 8'h00);
    wr(2'd3, 8'h00);
    check("R5 ack releases", {7'b0, int_n}, 8'h01);
    batt_low = 1;
    tick();
    check("R5 asserts again", {7'b0, int_n}, 8'h00);
    wr(2'd3, 8'h00);
    check("R5 still pending", {7'b0, int_n}, 8'h00);
    batt_low = 0;
    wr(2'd3, 8'h00);
    check("R5 high when idle", {7'b0, int_n}, 8'h01);

    // NMI pulses
    pwr_fail = 1;
    tick();
    check("R6 pulse", {7'b0, nmi}, 8'h01);
    tick();
    check("R6 single cycle", {7'b0, nmi}, 8'h00);
    pwr_fail = 0;
    tick();
    card_change = 1;
    tick();
    check("R6 card pulse", {7'b0, nmi}, 8'h01);
    pwr_fail = 1;
    tick();
    check("R6 consecutive pulse", {7'b0, nmi}, 8'h01);
    tick();
    check("R6 pulse ends", {7'b0, nmi}, 8'h00);
    check("R6 no int from nmi", {7'b0, int_n}, 8'h01);

    finish_run();
  end
endmodule